// File: doc/BRIEF.md
# Redirection Interrupt Message Dispatcher

This block turns interrupt events on numbered input lines into interrupt messages. Each line has a redirection entry, supplied as a flat table input by a register file outside the block. When an event arrives, the block checks the line's entry. A masked entry drops the event. An entry with a reserved delivery mode is flagged. A legal entry sets a pending bit for that line. Pending lines are serviced one at a time, lowest line number first. Each serviced line produces one or more messages on a valid/ready message port.

The destination mode decides how many messages a line produces. In physical mode the block sends exactly one message, addressed to the entry's destination field. In logical mode the 8-bit destination is a bitmask. The block walks it from bit 0 upward and sends one unicast message per set bit, addressed to that bit's position. For the ExtInt delivery mode, the vector is not taken from the table. The block requests it from a legacy controller over a request/response handshake and holds the message until the vector arrives.

Back-pressure rules:
- Once `msg_valid_o` is high, it stays high and every message field stays unchanged until a cycle in which `msg_ready_i` is high.
- The logical fan-out moves to the next bit only on such a handshake.
- `vreq_valid_o` stays high until `vreq_ready_i` is seen.
- A vector response is accepted only in a cycle where both `vrsp_valid_i` and `vrsp_ready_o` are high.
- Event inputs are never back-pressured. Events that arrive while the block is busy wait as pending bits.

Top module: `irq_msg_dispatch`

## Requirements

Entry layout: each entry is `ENT_W` = 23 bits wide, and line n sits at `tbl_i[n*23 +: 23]`. The fields within an entry are:
- bits [7:0]: vector
- bits [10:8]: delivery mode
- bit 11: destination mode (0 = physical, 1 = logical)
- bit 12: polarity
- bit 13: trigger
- bit 14: mask
- bits [22:15]: destination

Delivery-mode code 3'b111 is ExtInt.

- R1: An event on a line whose entry has mask bit 14 set produces no message and no error pulse, and leaves no pending state behind.
- R2: Each message copies these entry fields: delivery mode to `msg_dmode_o`, destination mode to `msg_logical_o`, polarity bit 12 to `msg_level_o`, and trigger bit 13 to `msg_trigger_o`. For every delivery mode except ExtInt, `msg_vector_o` is entry bits [7:0].
- R3: With delivery mode 3'b111, the block raises `vreq_valid_o` and holds it until `vreq_ready_i`. It then waits for a vector response. No message is offered before the response is accepted, and the message carries the response vector instead of the table vector.
- R4: An event on an unmasked line whose delivery mode is 3'b011 or 3'b110 produces no message. It causes a one-cycle `rsvd_err_o` pulse in the cycle after the event, with `err_line_o` equal to the line number.
- R5: In physical mode (bit 11 = 0), exactly one message is sent, and `msg_dest_o` equals entry bits [22:15].
- R6: In logical mode (bit 11 = 1), one message is sent per set bit of the destination, in ascending bit order, with `msg_dest_o` equal to the bit position. A zero destination sends nothing.
- R7: An event with `evt_line_i` at or above `NUM_LINES` produces no message. It causes a one-cycle `bad_line_o` pulse in the cycle after the event, with `err_line_o` equal to the line number.
- R8: While `msg_valid_o` is high and `msg_ready_i` is low, the message and all its fields hold. Fan-out advances only on a handshake.
- R9: Events that arrive while the block is busy are held as pending and serviced in ascending line order. A repeated event on a line that is already pending merges into one service.
- R10: After reset, `msg_valid_o`, `vreq_valid_o`, `rsvd_err_o` and `bad_line_o` are low. An event on an idle block raises `msg_valid_o` two cycles after the event cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_i | input | NUM_LINES*23 | Flattened redirection table |
| evt_valid_i | input | 1 | Event strobe, one per cycle |
| evt_line_i | input | LINE_W | Line number of the event |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Message accepted |
| msg_dest_o | output | 8 | Destination ID |
| msg_vector_o | output | 8 | Interrupt vector |
| msg_dmode_o | output | 3 | Delivery mode |
| msg_logical_o | output | 1 | Destination mode of the entry |
| msg_level_o | output | 1 | Level, taken from polarity |
| msg_trigger_o | output | 1 | Trigger mode |
| vreq_valid_o | output | 1 | Vector request to the legacy controller |
| vreq_ready_i | input | 1 | Vector request accepted |
| vrsp_valid_i | input | 1 | Vector response valid |
| vrsp_vector_i | input | 8 | Vector response value |
| vrsp_ready_o | output | 1 | Block waiting for a vector response |
| rsvd_err_o | output | 1 | Reserved delivery-mode pulse |
| bad_line_o | output | 1 | Illegal line number pulse |
| err_line_o | output | LINE_W | Line number of the last error |

## Verification

Some properties are checked by assertions on every cycle:
- the message and the vector request hold under back-pressure;
- no message ever carries a reserved delivery mode;
- no message is offered while a vector request is outstanding;
- a physical handshake is never followed directly by another offer;
- a line is only taken for service if it is pending;
- a masked event leaves the pending state untouched.

Other behaviour can only be shown by the directed scenarios:
- the exact sequence of fan-out destinations;
- the ascending service order and the merging of repeated events;
- the substitution of the fetched vector for the table vector;
- the timing of the error pulses and of the first message.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  localparam int DEST_W = 8;
  localparam int VEC_W  = 8;
  localparam int DM_W   = 3;

  // Field order matches the flat table layout: vector sits in the low bits.
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trigger;
    logic              polarity;
    logic              dest_mode;
    logic [DM_W-1:0]   dmode;
    logic [VEC_W-1:0]  vector;
  } entry_t;

  localparam int ENT_W = $bits(entry_t);

  localparam logic [DM_W-1:0] DM_EXTINT = 3'b111;
  localparam logic [DM_W-1:0] DM_RSVD_A = 3'b011;
  localparam logic [DM_W-1:0] DM_RSVD_B = 3'b110;

  typedef enum logic [1:0] {ST_IDLE, ST_VREQ, ST_VRSP, ST_SEND} fan_state_t;

  function automatic logic is_rsvd(logic [DM_W-1:0] dm);
    return (dm == DM_RSVD_A) || (dm == DM_RSVD_B);
  endfunction

  // Position of the lowest set bit (0 when the value is zero).
  function automatic logic [DEST_W-1:0] low_pos(logic [DEST_W-1:0] v);
    logic [DEST_W-1:0] p;
    p = '0;
    for (int i = DEST_W - 1; i >= 0; i--) begin
      if (v[i]) p = DEST_W'(i);
    end
    return p;
  endfunction

endpackage

// File: rtl/irqd_pick.sv
module irqd_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/irqd_intake.sv
module irqd_intake
  import irqd_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int IDX_W     = 5,
  parameter int LINE_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid_i,
  input  logic [LINE_W-1:0]    evt_line_i,
  input  entry_t               evt_ent_i,
  input  logic                 take_i,
  input  logic [IDX_W-1:0]     take_idx_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 rsvd_err_o,
  output logic                 bad_line_o,
  output logic [LINE_W-1:0]    err_line_o
);

  logic                 legal;
  logic                 accept;
  logic [NUM_LINES-1:0] set_vec;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] pend_q;

  assign legal   = evt_line_i < LINE_W'(NUM_LINES);
  assign accept  = evt_valid_i && legal && !evt_ent_i.mask && !is_rsvd(evt_ent_i.dmode);
  assign set_vec = accept ? (NUM_LINES'(1) << evt_line_i[IDX_W-1:0]) : '0;
  assign clr_vec = take_i ? (NUM_LINES'(1) << take_idx_i) : '0;
  assign pend_o  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      rsvd_err_o <= 1'b0;
      bad_line_o <= 1'b0;
      err_line_o <= '0;
    end else begin
      pend_q     <= (pend_q & ~clr_vec) | set_vec;
      bad_line_o <= evt_valid_i && !legal;
      rsvd_err_o <= evt_valid_i && legal && !evt_ent_i.mask && is_rsvd(evt_ent_i.dmode);
      if (evt_valid_i && (!legal || (!evt_ent_i.mask && is_rsvd(evt_ent_i.dmode))))
        err_line_o <= evt_line_i;
    end
  end

  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> pend_q[take_idx_i]); // R9

  AST_MASK_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_i && legal && evt_ent_i.mask && !take_i) |=> pend_q == $past(pend_q)); // R1

endmodule

// File: rtl/irqd_fanout.sv
module irqd_fanout
  import irqd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_pend_i,
  input  entry_t            pick_ent_i,
  output logic              take_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [DEST_W-1:0] msg_dest_o,
  output logic [VEC_W-1:0]  msg_vector_o,
  output logic [DM_W-1:0]   msg_dmode_o,
  output logic              msg_logical_o,
  output logic              msg_level_o,
  output logic              msg_trigger_o,
  output logic              vreq_valid_o,
  input  logic              vreq_ready_i,
  input  logic              vrsp_valid_i,
  input  logic [VEC_W-1:0]  vrsp_vector_i,
  output logic              vrsp_ready_o
);

  fan_state_t        st_q;
  entry_t            ent_q;
  logic [DEST_W-1:0] rem_q;
  logic [DEST_W-1:0] rem_nx;
  logic [VEC_W-1:0]  vec_q;

  assign take_o       = (st_q == ST_IDLE) && any_pend_i;
  assign rem_nx       = rem_q & (rem_q - DEST_W'(1));
  assign msg_valid_o  = (st_q == ST_SEND);
  assign vreq_valid_o = (st_q == ST_VREQ);
  assign vrsp_ready_o = (st_q == ST_VRSP);

  assign msg_dest_o    = ent_q.dest_mode ? low_pos(rem_q) : ent_q.dest;
  assign msg_vector_o  = vec_q;
  assign msg_dmode_o   = ent_q.dmode;
  assign msg_logical_o = ent_q.dest_mode;
  assign msg_level_o   = ent_q.polarity;
  assign msg_trigger_o = ent_q.trigger;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ent_q <= '0;
      rem_q <= '0;
      vec_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (any_pend_i) begin
          ent_q <= pick_ent_i;
          rem_q <= pick_ent_i.dest;
          vec_q <= pick_ent_i.vector;
          if (is_rsvd(pick_ent_i.dmode))
            st_q <= ST_IDLE;
          else if (pick_ent_i.dest_mode && (pick_ent_i.dest == '0))
            st_q <= ST_IDLE;
          else if (pick_ent_i.dmode == DM_EXTINT)
            st_q <= ST_VREQ;
          else
            st_q <= ST_SEND;
        end
        ST_VREQ: if (vreq_ready_i) st_q <= ST_VRSP;
        ST_VRSP: if (vrsp_valid_i) begin
          vec_q <= vrsp_vector_i;
          st_q  <= ST_SEND;
        end
        ST_SEND: if (msg_ready_i) begin
          rem_q <= rem_nx;
          if (!ent_q.dest_mode || (rem_nx == '0)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_dest_o) &&
      $stable(msg_vector_o) && $stable(msg_dmode_o) && $stable(msg_level_o))); // R8

  AST_NO_RSVD_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o |-> !is_rsvd(msg_dmode_o)); // R4

  AST_VREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vreq_valid_o && !vreq_ready_i) |=> vreq_valid_o); // R3

  AST_NO_MSG_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (vreq_valid_o || vrsp_ready_o) |-> !msg_valid_o); // R3

  AST_PHYS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && msg_ready_i && !msg_logical_o) |=> !msg_valid_o); // R5

endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
  import irqd_pkg::*;
#(
  parameter int NUM_LINES = 24,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int LINE_W   = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES*ENT_W-1:0] tbl_i,
  input  logic                       evt_valid_i,
  input  logic [LINE_W-1:0]          evt_line_i,
  output logic                       msg_valid_o,
  input  logic                       msg_ready_i,
  output logic [DEST_W-1:0]          msg_dest_o,
  output logic [VEC_W-1:0]           msg_vector_o,
  output logic [DM_W-1:0]            msg_dmode_o,
  output logic                       msg_logical_o,
  output logic                       msg_level_o,
  output logic                       msg_trigger_o,
  output logic                       vreq_valid_o,
  input  logic                       vreq_ready_i,
  input  logic                       vrsp_valid_i,
  input  logic [VEC_W-1:0]           vrsp_vector_i,
  output logic                       vrsp_ready_o,
  output logic                       rsvd_err_o,
  output logic                       bad_line_o,
  output logic [LINE_W-1:0]          err_line_o
);

  entry_t               tbl_a [NUM_LINES];
  logic [NUM_LINES-1:0] pend;
  logic                 any_pend;
  logic [IDX_W-1:0]     pick_idx;
  logic [IDX_W-1:0]     evt_sel;
  logic                 take;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_unpack
    assign tbl_a[g] = entry_t'(tbl_i[g*ENT_W +: ENT_W]);
  end

  assign evt_sel = (evt_line_i < LINE_W'(NUM_LINES)) ? evt_line_i[IDX_W-1:0] : '0;

  irqd_intake #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_intake (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid_i(evt_valid_i),
    .evt_line_i (evt_line_i),
    .evt_ent_i  (tbl_a[evt_sel]),
    .take_i     (take),
    .take_idx_i (pick_idx),
    .pend_o     (pend),
    .rsvd_err_o (rsvd_err_o),
    .bad_line_o (bad_line_o),
    .err_line_o (err_line_o)
  );

  irqd_pick #(.N(NUM_LINES), .IW(IDX_W)) u_pick (
    .req_i(pend),
    .any_o(any_pend),
    .idx_o(pick_idx)
  );

  irqd_fanout #(.IDX_W(IDX_W)) u_fanout (
    .clk          (clk),
    .rst_n        (rst_n),
    .any_pend_i   (any_pend),
    .pick_ent_i   (tbl_a[pick_idx]),
    .take_o       (take),
    .msg_valid_o  (msg_valid_o),
    .msg_ready_i  (msg_ready_i),
    .msg_dest_o   (msg_dest_o),
    .msg_vector_o (msg_vector_o),
    .msg_dmode_o  (msg_dmode_o),
    .msg_logical_o(msg_logical_o),
    .msg_level_o  (msg_level_o),
    .msg_trigger_o(msg_trigger_o),
    .vreq_valid_o (vreq_valid_o),
    .vreq_ready_i (vreq_ready_i),
    .vrsp_valid_i (vrsp_valid_i),
    .vrsp_vector_i(vrsp_vector_i),
    .vrsp_ready_o (vrsp_ready_o)
  );

endmodule

// File: tb/test_irq_msg_dispatch.sv
module test_irq_msg_dispatch;
  import irqd_pkg::*;

  localparam int NL = 24;
  localparam int LW = $clog2(NL) + 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NL*ENT_W-1:0] tbl = '0;
  logic                evt_valid = 1'b0;
  logic [LW-1:0]       evt_line = '0;
  logic                msg_valid, msg_ready = 1'b1;
  logic [7:0]          msg_dest, msg_vector;
  logic [2:0]          msg_dmode;
  logic                msg_logical, msg_level, msg_trigger;
  logic                vreq_valid, vreq_ready = 1'b0;
  logic                vrsp_valid = 1'b0;
  logic [7:0]          vrsp_vector = '0;
  logic                vrsp_ready, rsvd_err, bad_line;
  logic [LW-1:0]       err_line;

  int n_chk = 0;
  int n_fail = 0;
  logic [22:0] rxq[$];   // {dest, vector, dmode, logical, level, trigger}
  int          hold_err = 0;
  logic [22:0] prev_pkt;
  logic        prev_stall = 1'b0;

  always #10 clk = ~clk;

  irq_msg_dispatch #(.NUM_LINES(NL)) i_irq_msg_dispatch (
    .clk(clk), .rst_n(rst_n), .tbl_i(tbl),
    .evt_valid_i(evt_valid), .evt_line_i(evt_line),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_dest_o(msg_dest), .msg_vector_o(msg_vector), .msg_dmode_o(msg_dmode),
    .msg_logical_o(msg_logical), .msg_level_o(msg_level), .msg_trigger_o(msg_trigger),
    .vreq_valid_o(vreq_valid), .vreq_ready_i(vreq_ready),
    .vrsp_valid_i(vrsp_valid), .vrsp_vector_i(vrsp_vector), .vrsp_ready_o(vrsp_ready),
    .rsvd_err_o(rsvd_err), .bad_line_o(bad_line), .err_line_o(err_line)
  );

  // Message monitor, sampled midway between edges.
  always @(negedge clk) begin
    logic [22:0] pkt;
    pkt = {msg_dest, msg_vector, msg_dmode, msg_logical, msg_level, msg_trigger};
    if (prev_stall && (!msg_valid || pkt != prev_pkt)) hold_err++;
    prev_stall = msg_valid && !msg_ready;
    prev_pkt   = pkt;
    if (msg_valid && msg_ready) rxq.push_back(pkt);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic set_ent(input int ln, input logic [7:0] vec, input logic [2:0] dm,
                         input logic lg, input logic pol, input logic trg,
                         input logic msk, input logic [7:0] dst);
    tbl[ln*ENT_W +: ENT_W] = {dst, msk, trg, pol, lg, dm, vec};
  endtask

  task automatic fire(input int ln);
    @(posedge clk); #1;
    evt_valid = 1'b1;
    evt_line  = LW'(ln);
    @(posedge clk); #1;
    evt_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_msg(input string req, input logic [7:0] dst, input logic [7:0] vec,
                            input logic [2:0] dm, input logic lg, input logic pol, input logic trg);
    logic [22:0] exp;
    logic [22:0] got;
    exp = {dst, vec, dm, lg, pol, trg};
    got = (rxq.size() > 0) ? rxq.pop_front() : 23'h7fffff;
    chk(got == exp, req, 32'(got), 32'(exp));
  endtask

  task automatic t_reset();
    chk(!msg_valid && !vreq_valid, "R10 reset message/request", {30'd0, msg_valid, vreq_valid}, 0);
    chk(!rsvd_err && !bad_line, "R10 reset errors", {30'd0, rsvd_err, bad_line}, 0);
  endtask

  task automatic t_physical();
    set_ent(2, 8'h42, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h12);
    fire(2);
    chk(!msg_valid, "R10 no message one cycle after event", 32'(msg_valid), 0);
    idle(1);
    chk(msg_valid, "R10 message two cycles after event", 32'(msg_valid), 1);
    idle(4);
    chk(rxq.size() == 1, "R5 exactly one physical message", rxq.size(), 1);
    expect_msg("R5 physical fields", 8'h12, 8'h42, 3'b000, 1'b0, 1'b1, 1'b0);
    set_ent(11, 8'hB3, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE7);
    fire(11);
    idle(5);
    expect_msg("R2 copied mode/level/trigger", 8'hE7, 8'hB3, 3'b001, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_masked();
    set_ent(4, 8'h44, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03);
    fire(4);
    chk(!rsvd_err && !bad_line, "R1 masked raises no error", {30'd0, rsvd_err, bad_line}, 0);
    idle(6);
    chk(rxq.size() == 0, "R1 masked event dropped", rxq.size(), 0);
    set_ent(4, 8'h44, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03);
    set_ent(5, 8'h45, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05);
    fire(5);
    idle(5);
    chk(rxq.size() == 1, "R1 no pending left from masked event", rxq.size(), 1);
    expect_msg("R1 only the unmasked line serviced", 8'h05, 8'h45, 3'b000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_logical();
    set_ent(7, 8'h47, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 8'b1010_0101);
    fire(7);
    idle(10);
    chk(rxq.size() == 4, "R6 one message per set bit", rxq.size(), 4);
    expect_msg("R6 id 0", 8'd0, 8'h47, 3'b000, 1'b1, 1'b1, 1'b1);
    expect_msg("R6 id 2", 8'd2, 8'h47, 3'b000, 1'b1, 1'b1, 1'b1);
    expect_msg("R6 id 5", 8'd5, 8'h47, 3'b000, 1'b1, 1'b1, 1'b1);
    expect_msg("R6 id 7", 8'd7, 8'h47, 3'b000, 1'b1, 1'b1, 1'b1);
    set_ent(8, 8'h48, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    fire(8);
    idle(6);
    chk(rxq.size() == 0, "R6 zero destination sends nothing", rxq.size(), 0);
  endtask

  task automatic t_extint();
    set_ent(10, 8'h55, DM_EXTINT, 1'b0, 1'b0, 1'b1, 1'b0, 8'h22);
    fire(10);
    idle(4);
    chk(vreq_valid, "R3 request held without ready", 32'(vreq_valid), 1);
    chk(!msg_valid && rxq.size() == 0, "R3 no message before vector", 32'(msg_valid), 0);
    vreq_ready = 1'b1;
    idle(1);
    vreq_ready = 1'b0;
    chk(!vreq_valid && vrsp_ready, "R3 waiting for response", {30'd0, vreq_valid, vrsp_ready}, 1);
    idle(3);
    chk(!msg_valid, "R3 message waits for response", 32'(msg_valid), 0);
    vrsp_valid  = 1'b1;
    vrsp_vector = 8'h9C;
    idle(1);
    vrsp_valid = 1'b0;
    idle(3);
    expect_msg("R3 vector from legacy controller", 8'h22, 8'h9C, DM_EXTINT, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reserved();
    set_ent(6, 8'h46, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    set_ent(13, 8'h4D, 3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    fire(6);
    chk(rsvd_err && err_line == 6, "R4 code 011 flagged", 32'(err_line), 6);
    idle(1);
    chk(!rsvd_err, "R4 pulse lasts one cycle", 32'(rsvd_err), 0);
    fire(13);
    chk(rsvd_err && err_line == 13, "R4 code 110 flagged", 32'(err_line), 13);
    idle(8);
    chk(rxq.size() == 0, "R4 reserved sends nothing", rxq.size(), 0);
  endtask

  task automatic t_bad_line();
    fire(NL);
    chk(bad_line && err_line == LW'(NL), "R7 line at depth flagged", 32'(err_line), NL);
    idle(1);
    chk(!bad_line, "R7 pulse lasts one cycle", 32'(bad_line), 0);
    fire(63);
    chk(bad_line && err_line == 63, "R7 top line flagged", 32'(err_line), 63);
    idle(6);
    chk(rxq.size() == 0, "R7 illegal line not serviced", rxq.size(), 0);
  endtask

  task automatic t_backpressure();
    set_ent(15, 8'h4F, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'b0001_1010);
    hold_err = 0;
    @(posedge clk); #1;
    msg_ready = 1'b0;
    fire(15);
    for (int i = 0; i < 20; i++) begin
      idle(1);
      msg_ready = (i % 3 == 2);
    end
    msg_ready = 1'b1;
    idle(3);
    chk(hold_err == 0, "R8 message stable while stalled", hold_err, 0);
    chk(rxq.size() == 3, "R8 one advance per handshake", rxq.size(), 3);
    expect_msg("R8 id 1", 8'd1, 8'h4F, 3'b000, 1'b1, 1'b0, 1'b0);
    expect_msg("R8 id 3", 8'd3, 8'h4F, 3'b000, 1'b1, 1'b0, 1'b0);
    expect_msg("R8 id 4", 8'd4, 8'h4F, 3'b000, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_pending_order();
    set_ent(1, 8'h41, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    set_ent(3, 8'h43, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h13);
    set_ent(9, 8'h49, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h19);
    fire(1);
    fire(9);
    fire(3);
    fire(5);
    fire(3);
    idle(20);
    chk(rxq.size() == 11, "R9 busy events merged and kept", rxq.size(), 11);
    for (int i = 0; i < 8; i++)
      expect_msg("R9 first line fan-out", 8'(i), 8'h41, 3'b000, 1'b1, 1'b0, 1'b0);
    expect_msg("R9 line 3 next", 8'h13, 8'h43, 3'b000, 1'b0, 1'b0, 1'b0);
    expect_msg("R9 line 5 next", 8'h05, 8'h45, 3'b000, 1'b0, 1'b0, 1'b0);
    expect_msg("R9 line 9 last", 8'h19, 8'h49, 3'b000, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < NL; i++) set_ent(i, 8'h00, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_physical();
    t_masked();
    t_logical();
    t_extint();
    t_reserved();
    t_bad_line();
    t_backpressure();
    t_pending_order();
    report();
  end

endmodule